// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Override

This block decides the level of a single PWM output from strobes that a time-base counter produces elsewhere: counter at zero, counter at period, compare match while counting up, and compare match while counting down. Each strobe has its own two-bit action input that says what the output does when that strobe fires: nothing, go low, go high or invert. The action inputs are used on the same clock edge as the strobes. No setting is buffered until a later counter event.

A continuous override input sits above the event logic. It can hold the output low or high for as long as it is applied. While it is applied the event actions have no effect on the output. When it is removed, event control resumes from the level the override left behind. Software can therefore freeze the pin, reprogram every action, and then release it. The output comes from a register and changes only on a clock edge.

Top module: `pwm_aq_out`

## Requirements
- R1: While `rst` is high, `pwm_out` is 0 after the next clock edge.
- R2: Action code 2'b00 means no action, 2'b01 drives the output low, 2'b10 drives it high and 2'b11 inverts it. When one strobe with a non-zero action fires alone and no override is applied, `pwm_out` shows the result on the next clock edge.
- R3: If several strobes that carry a non-zero action fire in the same cycle, only one action is applied. The order of precedence, highest first, is zero, period, compare-up, compare-down. A strobe whose action is 2'b00 does not block a lower one.
- R4: Override code 2'b01 makes `pwm_out` 0 and code 2'b10 makes it 1 at the next clock edge. This holds for every combination of strobes and actions.
- R5: Override codes 2'b00 and 2'b11 leave the output to the strobes. After an override is removed, the output starts from the forced level and the event actions work from there.
- R6: With no override, and with no strobe that carries a non-zero action, `pwm_out` keeps its value.
- R7: An action value, or an override value, that changes in a cycle is used at that cycle's clock edge. The value it held before has no effect.
- R8: If the compare strobes never fire during a counter period, their actions are skipped. The output then stays at the level set by the zero and period actions. For example, clear at zero with no period action keeps the output at 0 for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_zero | input | 1 | Counter-at-zero strobe |
| ev_period | input | 1 | Counter-at-period strobe |
| ev_cmp_up | input | 1 | Compare match while counting up |
| ev_cmp_dn | input | 1 | Compare match while counting down |
| act_zero | input | 2 | Action for the zero strobe |
| act_period | input | 2 | Action for the period strobe |
| act_cmp_up | input | 2 | Action for the compare-up strobe |
| act_cmp_dn | input | 2 | Action for the compare-down strobe |
| force_mode | input | 2 | Continuous override: 00/11 off, 01 low, 10 high |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a strobe that fires with a chosen output level already in place, combined with every mix of coinciding strobes, actions and override codes. This matters most for toggles and for the level after an override is released. Each trial first applies an override for one cycle to place the output at a known 0 or 1. On the next cycle it presents the strobe mask, the four actions and the override code under test. The bench sweeps all 2×16×256×4 combinations and computes the expected level arithmetically from the priority rule.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_LOW  = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_OFF2 = 2'b11
  } aq_frc_e;

  localparam int ACT_W = 2;

  function automatic logic apply_act(input aq_act_e a, input logic lvl);
    case (a)
      ACT_CLR: apply_act = 1'b0;
      ACT_SET: apply_act = 1'b1;
      ACT_TGL: apply_act = ~lvl;
      default: apply_act = lvl;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_arbiter.sv
module pwm_aq_arbiter
  import pwm_aq_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic [NUM_EVT-1:0]       evt,
  input  logic [NUM_EVT*ACT_W-1:0] act_flat,
  output aq_act_e                  act_win
);
  logic [NUM_EVT-1:0] live;
  aq_act_e            act_arr [NUM_EVT];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_slot
      assign act_arr[gi] = aq_act_e'(act_flat[gi*ACT_W +: ACT_W]);
      assign live[gi]    = evt[gi] && (act_arr[gi] != ACT_NONE);
    end
  endgenerate

  // index 0 has the highest precedence: it is written last
  always_comb begin
    act_win = ACT_NONE;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (live[i]) act_win = act_arr[i];
    end
  end

  // R3
  win_from_live_chk: assert final ((live == '0) == (act_win == ACT_NONE));
endmodule

// File: rtl/pwm_aq_level.sv
module pwm_aq_level
  import pwm_aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  aq_frc_e frc,
  input  aq_act_e act_win,
  output logic    lvl_q
);
  logic lvl_d;

  always_comb begin
    case (frc)
      FRC_LOW:  lvl_d = 1'b0;
      FRC_HIGH: lvl_d = 1'b1;
      default:  lvl_d = apply_act(act_win, lvl_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_d;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !lvl_q);
  // R4
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    frc == FRC_LOW |=> !lvl_q);
  // R4
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    frc == FRC_HIGH |=> lvl_q);
endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_zero,
  input  logic       ev_period,
  input  logic       ev_cmp_up,
  input  logic       ev_cmp_dn,
  input  logic [1:0] act_zero,
  input  logic [1:0] act_period,
  input  logic [1:0] act_cmp_up,
  input  logic [1:0] act_cmp_dn,
  input  logic [1:0] force_mode,
  output logic       pwm_out
);
  localparam int NUM_EVT = 4;

  logic [NUM_EVT-1:0]       evt_vec;
  logic [NUM_EVT*ACT_W-1:0] act_vec;
  aq_act_e                  act_win;
  aq_frc_e                  frc;
  logic                     released;

  // precedence order: slot 0 highest
  assign evt_vec  = {ev_cmp_dn, ev_cmp_up, ev_period, ev_zero};
  assign act_vec  = {act_cmp_dn, act_cmp_up, act_period, act_zero};
  assign frc      = aq_frc_e'(force_mode);
  assign released = (frc == FRC_OFF) || (frc == FRC_OFF2);

  pwm_aq_arbiter #(.NUM_EVT(NUM_EVT)) u_arb (
    .evt      (evt_vec),
    .act_flat (act_vec),
    .act_win  (act_win)
  );

  pwm_aq_level u_lvl (
    .clk     (clk),
    .rst     (rst),
    .frc     (frc),
    .act_win (act_win),
    .lvl_q   (pwm_out)
  );

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    released && !(ev_zero && act_zero != 2'b00) && !(ev_period && act_period != 2'b00)
    && !(ev_cmp_up && act_cmp_up != 2'b00) && !(ev_cmp_dn && act_cmp_dn != 2'b00)
    |=> $stable(pwm_out));
  // R3
  zero_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    released && ev_zero && act_zero == 2'b10 |=> pwm_out);
  // R3
  zero_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    released && ev_zero && act_zero == 2'b01 |=> !pwm_out);
  // R2
  zero_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    released && ev_zero && act_zero == 2'b11 |=> pwm_out != $past(pwm_out));
endmodule

// File: tb/pwm_aq_out_test.sv
module pwm_aq_out_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_zero = 0, ev_period = 0, ev_cmp_up = 0, ev_cmp_dn = 0;
  logic [1:0] act_zero = 0, act_period = 0, act_cmp_up = 0, act_cmp_dn = 0;
  logic [1:0] force_mode = 0;
  logic pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_aq_out uut (
    .clk(clk), .rst(rst),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmp_up(ev_cmp_up), .ev_cmp_dn(ev_cmp_dn),
    .act_zero(act_zero), .act_period(act_period), .act_cmp_up(act_cmp_up), .act_cmp_dn(act_cmp_dn),
    .force_mode(force_mode), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (pwm_out !== exp) begin
      bad++;
      $display("FAIL %s: pwm_out=%b expected=%b", req, pwm_out, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [7:0] a, input logic [1:0] f);
    {ev_cmp_dn, ev_cmp_up, ev_period, ev_zero} = m;
    {act_cmp_dn, act_cmp_up, act_period, act_zero} = a;
    force_mode = f;
  endtask

  // expected level from requirements R2..R6
  function automatic logic model(input logic lvl, input logic [3:0] m,
                                 input logic [7:0] a, input logic [1:0] f);
    logic [1:0] w;
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    w = 2'b00;
    for (int i = 0; i < 4; i++)
      if (w == 2'b00 && m[i] && a[2*i +: 2] != 2'b00) w = a[2*i +: 2];
    case (w)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~lvl;
      default: return lvl;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] m, input logic [7:0] a, input logic [1:0] f);
    int n = 0;
    if (f == 2'b01 || f == 2'b10) return "R4";
    for (int i = 0; i < 4; i++) if (m[i] && a[2*i +: 2] != 2'b00) n++;
    if (n == 0) return "R6";
    if (n > 1) return "R3";
    return "R2";
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1;
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(4'hF, 8'hAA, 2'b00);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    drive(4'h0, 8'h00, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);

    // R5: release after force high keeps level, then events act from there
    drive(4'h0, 8'h00, 2'b10); @(negedge clk);
    drive(4'h0, 8'h00, 2'b00); @(negedge clk);
    check("R5", 1'b1);
    drive(4'h1, 8'h03, 2'b11); @(negedge clk);
    check("R5", 1'b0);

    // R7: action changed in the same cycle as the strobe is the one used
    drive(4'h0, 8'h01, 2'b00); @(negedge clk);
    drive(4'h1, 8'h02, 2'b00); @(negedge clk);
    check("R7", 1'b1);
    drive(4'h1, 8'h02, 2'b01); @(negedge clk);
    check("R7", 1'b0);

    // R8: counter never reaches compare; zero clears, compare-up would set
    for (int p = 0; p < 3; p++) begin
      drive(4'h1, 8'h21, 2'b00); @(negedge clk);
      check("R8", 1'b0);
      for (int k = 0; k < 4; k++) begin
        drive(4'h0, 8'h21, 2'b00); @(negedge clk);
        check("R8", 1'b0);
      end
      drive(4'h2, 8'h21, 2'b00); @(negedge clk);
      check("R8", 1'b0);
    end

    // exhaustive sweep: R2 R3 R4 R5 R6
    for (int init = 0; init < 2; init++)
      for (int f = 0; f < 4; f++)
        for (int m = 0; m < 16; m++)
          for (int a = 0; a < 256; a++) begin
            drive(4'h0, 8'h00, init[0] ? 2'b10 : 2'b01);
            @(negedge clk);
            drive(m[3:0], a[7:0], f[1:0]);
            @(negedge clk);
            check(tag(m[3:0], a[7:0], f[1:0]),
                  model(init[0], m[3:0], a[7:0], f[1:0]));
          end

    drive(4'h0, 8'h00, 2'b00);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule